// File: doc/BRIEF.md
# A-law Telephony TDM Serial Port

This block is the serial end of a 2.048 Mbit/s telephony time-division link that carries 32 eight-bit channels per frame. It divides an external 4.096 MHz source clock by two to make the bit clock, follows an active-low frame sync, and moves one 8-bit A-law sample per channel in each direction. The parallel side of the block works only with 16-bit linear words. On receive, each sample is expanded to a 13-bit linear value and left-justified into 16 bits. On transmit, each 16-bit linear word is compressed back to A-law before it is shifted out.

On receive, each completed slot produces a one-cycle ready pulse together with the slot number and the expanded word. On transmit, a single holding register is used. Logic upstream writes the linear word for a slot at any time before that slot begins. At the start of every slot the port empties the holding register into its shifter and pulses a take strobe that carries the slot number. If the holding register is empty when a slot starts, the A-law idle code goes out in that slot.

Top module: `tdm_alaw_port`

## Requirements
- R1: While reset is held, `bclk` is 0, `tx_d` is 1, and `rx_valid` and `tx_take` are 0.
- R2: `bclk` toggles once for every falling edge of `src_clk`, so it runs at half the source rate. Its period is two source periods.
- R3: A frame holds 32 slots of 8 bits, sent and received MSB first. The rising `bclk` edge at which `fs_n` is sampled low carries bit 7 of slot 0, with no added bit delay.
- R4: A received byte c is expanded as follows. Let x = c XOR 0x55. Let s = x[6:4] and m = x[3:0]. The magnitude t is 16m+8 when s=0, and (16m+264)·2^(s−1) otherwise. `rx_word` is t when x[7]=1 and −t when x[7]=0. Its three low bits are always 0.
- R5: `rx_valid` is a one-clock pulse that follows the rising `bclk` edge which samples the eighth bit of a slot. `rx_slot` gives the slot number 0 to 31. No pulse is issued before the first frame sync.
- R6: A word w that is sent is compressed as follows. Let v = w>>>3. The magnitude g is v when v≥0 and −v−1 otherwise, with mask 0xD5 or 0x55 respectively. The segment s is the smallest value with g < 32·2^s, capped at 7. The mantissa is (g>>1)&15 for s=0 and (g>>s)&15 otherwise. The code sent is ({s,mantissa}) XOR mask.
- R7: A slot that starts while the holding register is empty carries 0xD5.
- R8: A word written with `tx_wr` is sent in the next slot to start. At each slot start, `tx_take` pulses for one clock with `tx_slot` equal to that slot. The slot numbers step by one, modulo 32.
- R9: `tx_d` and `tx_take` change only at a falling `bclk` edge. Receive sampling happens only at a rising `bclk` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_clk | input | 1 | External 4.096 MHz source clock |
| fs_n | input | 1 | Active-low frame sync |
| rx_d | input | 1 | Serial receive data |
| tx_d | output | 1 | Serial transmit data |
| bclk | output | 1 | Derived bit clock |
| rx_valid | output | 1 | Receive-word ready pulse |
| rx_slot | output | 5 | Slot of the received word |
| rx_word | output | 16 | Expanded, left-justified linear word |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_word | input | 16 | Linear word to transmit |
| tx_take | output | 1 | Slot-start pulse; holding register consumed |
| tx_slot | output | 5 | Slot that is starting |

## Verification
Across eight frames the receive side sees every one of the 256 A-law codes, each in a known slot. This tests the full expansion table, including segment zero and the sign bit. The transmit side sends the expansion of every code back out and must return the same byte. That round trip separates errors in segment choice from errors in mantissa extraction. A further frame leaves odd slots unwritten and fills even slots with spread linear values, which exposes idle-code insertion and holding-register clearing. A last frame drives powers of two of both signs along with both full-scale extremes, which probes the segment boundaries and the −1 rounding for negative words.

// File: rtl/tdm_alaw_port.sv
module tdm_alaw_port #(
  parameter int SLOTS  = 32,
  parameter int WORD_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       src_clk,
  input  logic                       fs_n,
  input  logic                       rx_d,
  output logic                       tx_d,
  output logic                       bclk,
  output logic                       rx_valid,
  output logic [$clog2(SLOTS)-1:0]   rx_slot,
  output logic [WORD_W-1:0]          rx_word,
  input  logic                       tx_wr,
  input  logic [WORD_W-1:0]          tx_word,
  output logic                       tx_take,
  output logic [$clog2(SLOTS)-1:0]   tx_slot
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int POS_W  = SLOT_W + 3;
  localparam logic [7:0] IDLE = 8'hD5;

  function automatic logic [15:0] alaw_dec(input logic [7:0] c);
    logic [7:0]  x;
    logic [15:0] t;
    x = c ^ 8'h55;
    if (x[6:4] == 3'd0) t = {8'd0, x[3:0], 4'h8};
    else t = {7'd0, 1'b1, x[3:0], 4'h8} << (x[6:4] - 3'd1);
    return x[7] ? t : -t;
  endfunction

  function automatic logic [7:0] alaw_enc(input logic [15:0] w);
    logic [12:0] v;
    logic [11:0] m;
    logic [2:0]  sg;
    logic [3:0]  mt;
    v  = w[15:3];
    m  = v[12] ? ~v[11:0] : v[11:0];
    sg = 3'd0;
    for (int k = 5; k < 12; k++) if (m[k]) sg = 3'(k - 4);
    mt = (sg == 3'd0) ? m[4:1] : 4'(m >> sg);
    return {~v[12], sg, mt} ^ 8'h55;
  endfunction

  logic [2:0] src_s;
  logic [POS_W-1:0] pos;
  logic       locked;
  logic [6:0] rx_sh;
  logic [7:0] tx_sh;
  logic       tx_full;
  logic [WORD_W-1:0] tx_hold;

  wire src_fall = src_s[2] & ~src_s[1];
  wire smp_ev   = src_fall & ~bclk;
  wire drv_ev   = src_fall & bclk;
  wire [POS_W-1:0] pos_now = !fs_n ? '0 : pos + 1'b1;
  wire [POS_W-1:0] pos_nx  = pos + 1'b1;
  wire slot_start = drv_ev && (pos_nx[2:0] == 3'd0);
  wire [7:0] tx_byte = tx_full ? alaw_enc(tx_hold[15:0]) : IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_s <= 3'b000;
      bclk  <= 1'b0;
    end else begin
      src_s <= {src_s[1:0], src_clk};
      if (src_fall) bclk <= ~bclk;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos      <= '1;
      locked   <= 1'b0;
      rx_sh    <= '0;
      rx_valid <= 1'b0;
      rx_slot  <= '0;
      rx_word  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (smp_ev) begin
        pos   <= pos_now;
        rx_sh <= {rx_sh[5:0], rx_d};
        if (!fs_n) locked <= 1'b1;
        if (locked && pos_now[2:0] == 3'd7) begin
          rx_valid <= 1'b1;
          rx_slot  <= pos_now[POS_W-1:3];
          rx_word  <= WORD_W'(alaw_dec({rx_sh, rx_d}));
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_d    <= 1'b1;
      tx_sh   <= IDLE;
      tx_full <= 1'b0;
      tx_hold <= '0;
      tx_take <= 1'b0;
      tx_slot <= '0;
    end else begin
      tx_take <= 1'b0;
      if (slot_start) begin
        tx_sh   <= tx_byte;
        tx_d    <= tx_byte[7];
        tx_full <= 1'b0;
        tx_take <= 1'b1;
        tx_slot <= pos_nx[POS_W-1:3];
      end else if (drv_ev) begin
        tx_sh <= {tx_sh[6:0], 1'b0};
        tx_d  <= tx_sh[6];
      end
      if (tx_wr) begin
        tx_full <= 1'b1;
        tx_hold <= tx_word;
      end
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (!rx_valid && !tx_take));
  // R2
  bclk_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(bclk) |=> $stable(bclk));
  // R5
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |=> !rx_valid);
  // R4
  rx_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |-> rx_word[2:0] == 3'd0);
  // R9
  rx_edge_chk: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |-> $rose(bclk));
  // R9
  tx_edge_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(tx_d) |-> $fell(bclk));
  // R8
  take_edge_chk: assert property (@(posedge clk) disable iff (!rst_n) tx_take |-> $fell(bclk));
endmodule

// File: tb/sim_tdm_alaw_port.sv
`timescale 1ns/1ps
module sim_tdm_alaw_port;
  logic clk = 0, rst_n = 0, src_clk = 0, fs_n = 1, rx_d = 0, tx_wr = 0;
  logic [15:0] tx_word = 0;
  logic tx_d, bclk, rx_valid, tx_take;
  logic [4:0] rx_slot, tx_slot;
  logic [15:0] rx_word;

  int checks = 0, fails = 0, rxn = 0, takes = 0, prev_take = -1, bper = 0;
  bit done = 0;
  logic [7:0] exp_tx [0:351];
  realtime last_rise = 0;

  tdm_alaw_port u0 (.clk(clk), .rst_n(rst_n), .src_clk(src_clk), .fs_n(fs_n), .rx_d(rx_d),
    .tx_d(tx_d), .bclk(bclk), .rx_valid(rx_valid), .rx_slot(rx_slot), .rx_word(rx_word),
    .tx_wr(tx_wr), .tx_word(tx_word), .tx_take(tx_take), .tx_slot(tx_slot));

  always #5 clk = ~clk;
  initial forever #40 src_clk = ~src_clk;

  function automatic logic [15:0] ref_dec(input int c);
    int x, sg, m, t;
    x = (c ^ 'h55) & 255; sg = (x >> 4) & 7; m = x & 15;
    t = (sg == 0) ? m * 16 + 8 : (m * 16 + 264) * (1 << (sg - 1));
    return ((x & 'h80) != 0) ? 16'(t) : 16'(-t);
  endfunction

  function automatic logic [7:0] ref_enc(input logic [15:0] w);
    int v, g, mask, sg, mt;
    v = $signed(w); v = v >>> 3;
    if (v >= 0) begin g = v; mask = 'hD5; end else begin g = -v - 1; mask = 'h55; end
    sg = 0;
    while (sg < 7 && g >= (32 << sg)) sg++;
    mt = (sg == 0) ? (g >> 1) & 15 : (g >> sg) & 15;
    return 8'(((sg << 4) | mt) ^ mask);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, expv); end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (rx_valid) begin
      chk(rx_slot == 5'(rxn % 32), "R5 rx_slot", rx_slot, rxn % 32);
      chk(rx_word == ref_dec(rxn & 255), "R4 rx_word", rx_word, ref_dec(rxn & 255));
      rxn++;
    end
    if (tx_take) begin
      if (prev_take >= 0) chk(tx_slot == 5'((prev_take + 1) % 32), "R8 tx_slot", tx_slot, (prev_take + 1) % 32);
      prev_take = tx_slot; takes++;
    end
  end

  always @(posedge bclk) if (rst_n) begin
    if (last_rise > 0 && bper < 8) begin
      chk(($realtime - last_rise) == 160.0, "R2 bclk period", int'($realtime - last_rise), 160);
      bper++;
    end
    last_rise = $realtime;
  end

  initial begin
    #1500000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] txb;
    for (int i = 0; i < 352; i++) exp_tx[i] = 8'hD5;
    repeat (5) @(posedge clk);
    #1;
    chk(bclk == 0, "R1 bclk", bclk, 0);
    chk(tx_d == 1, "R1 tx_d", tx_d, 1);
    chk(!rx_valid && !tx_take, "R1 strobes", {rx_valid, tx_take}, 0);
    @(negedge clk) rst_n = 1;
    txb = 0;
    for (int f = 0; f < 11; f++) begin
      for (int b = 0; b < 256; b++) begin
        int s;
        logic [7:0] code;
        s = b / 8;
        code = 8'((f * 32 + s) & 255);
        @(negedge bclk); #1;
        fs_n = (b != 0);
        rx_d = code[7 - b % 8];
        @(posedge bclk); #1;
        txb = {txb[6:0], tx_d};
        if (b % 8 == 7 && (f > 0 || s > 0))
          chk(txb == exp_tx[f * 32 + s], "R3 R6 R7 tx byte", txb, exp_tx[f * 32 + s]);
        if (b % 8 == 4) begin
          int t, tf, ts;
          logic [15:0] w;
          bit skip;
          t = f * 32 + s + 1; tf = t / 32; ts = t % 32; skip = 0; w = 0;
          if (tf >= 1 && tf <= 8) w = ref_dec(((tf - 1) * 32 + ts) & 255);
          else if (tf == 9) begin
            if (ts % 2 == 1) skip = 1; else w = 16'(ts * 2000 - 31000);
          end else if (tf == 10) begin
            if (ts < 15) w = 16'(1 << ts);
            else if (ts < 30) w = 16'(-(1 << (ts - 15)));
            else if (ts == 30) w = 16'h7FFF;
            else w = 16'h8000;
          end else skip = 1;
          if (!skip) begin
            exp_tx[t] = (tf <= 8) ? 8'(((tf - 1) * 32 + ts) & 255) : ref_enc(w);
            @(negedge clk); tx_wr = 1; tx_word = w;
            @(negedge clk); tx_wr = 0;
          end
        end
      end
    end
    repeat (40) @(posedge clk);
    #1;
    chk(rxn == 352, "R5 rx count", rxn, 352);
    chk(takes >= 351 && takes <= 353, "R8 take count", takes, 352);
    chk(ref_enc(16'h8000) == 8'h2A, "R6 ref min", ref_enc(16'h8000), 'h2A);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule